// File: doc/BRIEF.md
# Load-Store Byte-Lane Unit

This block sits between a 32-bit processor's execute stage and its data memory. It has two jobs. For stores, it turns the register value into a memory write word and a set of byte enables. For loads, it takes the 32-bit word read from memory and produces the register result, picking out the addressed byte or halfword and extending it. The access size, a signed/unsigned flag and the two low address bits drive both jobs. Memory is little-endian, so byte lane k holds bits 8k+7 down to 8k.

Halfword and word accesses must be naturally aligned. When one is not, the block raises a misalignment flag, drops every byte enable and returns zero as the load result. The surrounding pipeline can then trap on the flag, and no memory bytes are corrupted. All outputs are registered, so the results appear one clock after the inputs are presented.

Top module: `lane_lsu`

## Requirements
- R1: While rst_n is low at a rising clock edge, every output (mem_be, mem_wdata, ld_result, misalign) becomes zero at that edge.
- R2: Every output reflects the inputs sampled at the previous rising edge. A change of inputs between edges leaves the outputs unchanged until the next edge.
- R3: A byte load (acc_size 2'b00, acc_unsigned 0) returns byte lane addr_lo of mem_rdata, sign-extended to 32 bits.
- R4: An unsigned byte load (acc_size 2'b00, acc_unsigned 1) returns byte lane addr_lo of mem_rdata, zero-extended.
- R5: A halfword load (acc_size 2'b01) returns mem_rdata bits 16h+15:16h, where h is addr_lo[1]. The value is sign-extended when acc_unsigned is 0 and zero-extended when it is 1.
- R6: An aligned word load (acc_size 2'b10) returns mem_rdata unchanged, whatever acc_unsigned is.
- R7: A byte store drives mem_be = 1 << addr_lo and replicates st_value[7:0] into all four lanes of mem_wdata.
- R8: An aligned halfword store drives mem_be = 4'b0011 when addr_lo[1] is 0 and 4'b1100 when it is 1. It replicates st_value[15:0] into both halves of mem_wdata.
- R9: An aligned word store drives mem_be = 4'b1111 and mem_wdata = st_value.
- R10: A halfword access with addr_lo[0] = 1, or a word access with addr_lo != 0, sets misalign and forces mem_be and ld_result to zero. Byte accesses never set misalign.
- R11: acc_size 2'b11 behaves exactly as a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| acc_unsigned | input | 1 | 1 selects zero extension on sub-word loads |
| addr_lo | input | 2 | Low two bits of the effective address |
| st_value | input | 32 | Register value to be stored |
| mem_rdata | input | 32 | Word read from memory |
| mem_be | output | 4 | Byte write enables, bit k for lane k |
| mem_wdata | output | 32 | Formatted memory write word |
| ld_result | output | 32 | Extracted and extended load result |
| misalign | output | 1 | Access is not naturally aligned |

## Verification
The bench sweeps every size code, both extension modes and all four low address values. It runs each combination against six data words whose lanes differ from one another and carry both set and clear top bits. Distinct lane contents show whether the right lane was selected. Top bits of 1 next to top bits of 0 show whether the extension mode was honoured. Sweeping every offset for each size covers both the aligned cases and every misaligned one. A reset check and a check between edges confirm the register stage.

// File: rtl/lsu_lane_pkg.sv
// Shared encodings for the load-store byte-lane unit.
// Assumes a 2-bit access-size field; code 2'b11 is treated as full width.
package lsu_lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lane_align_chk.sv
// Alignment checker: flags halfword accesses at odd offsets and full-width
// accesses at any nonzero offset. Assumes the offset is the byte offset
// within one data word.
module lane_align_chk
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             misalign
);
    // Decide alignment from the access size and the offset.
    always_comb begin
        unique case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = off[0];
            default: misalign = (off != '0);
        endcase
    end
endmodule

// File: rtl/lane_store_fmt.sv
// Store formatter: copies the store value into every lane at the access
// width and computes the byte enables. Assumes little-endian lanes; the
// enables are cleared when the access is misaligned.
module lane_store_fmt
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic              misalign,
    input  logic [DATA_W-1:0] st_value,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    logic [LANES-1:0] be_raw;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_byte;
        logic       lane_en;

        // Pick the source byte and the enable for this lane.
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    lane_byte = st_value[7:0];
                    lane_en   = (off == OFF_W'(g));
                end
                SZ_HALF: begin
                    lane_byte = st_value[(g % 2) * 8 +: 8];
                    lane_en   = ((off >> 1) == OFF_W'(g / 2));
                end
                default: begin
                    lane_byte = st_value[g * 8 +: 8];
                    lane_en   = 1'b1;
                end
            endcase
        end

        assign wdata[g * 8 +: 8] = lane_byte;
        assign be_raw[g]         = lane_en;
    end

    // Suppress every enable on a misaligned access.
    always_comb begin
        be = misalign ? '0 : be_raw;
    end
endmodule

// File: rtl/lane_load_ext.sv
// Load extractor: selects the addressed byte or halfword from the read word
// and sign- or zero-extends it. Assumes little-endian lanes; returns zero
// when the access is misaligned.
module lane_load_ext
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic              is_unsigned,
    input  logic [OFF_W-1:0]  off,
    input  logic              misalign,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    // Steer the addressed byte and halfword out of the read word.
    always_comb begin
        byte_sel = '0;
        half_sel = '0;
        for (int i = 0; i < LANES; i++) begin
            if (off == OFF_W'(i)) byte_sel = rdata[i * 8 +: 8];
        end
        for (int i = 0; i < LANES / 2; i++) begin
            if ((off >> 1) == OFF_W'(i)) half_sel = rdata[i * 16 +: 16];
        end
    end

    // Extend the selected field to full width, or zero it when misaligned.
    always_comb begin
        if (misalign) begin
            result = '0;
        end else begin
            unique case (size)
                SZ_BYTE: result = is_unsigned ? {{(DATA_W-8){1'b0}}, byte_sel}
                                              : {{(DATA_W-8){byte_sel[7]}}, byte_sel};
                SZ_HALF: result = is_unsigned ? {{(DATA_W-16){1'b0}}, half_sel}
                                              : {{(DATA_W-16){half_sel[15]}}, half_sel};
                default: result = rdata;
            endcase
        end
    end
endmodule

// File: rtl/lane_lsu.sv
// Load-store byte-lane unit: formats store data and enables, extracts load
// data, and flags misaligned accesses. All outputs are registered once.
// Assumes a 32-bit little-endian data word and a synchronous active-low reset.
module lane_lsu
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_size,
    input  logic              acc_unsigned,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] st_value,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] ld_result,
    output logic              misalign
);
    acc_size_e         size_q;
    logic              mis_d;
    logic [LANES-1:0]  be_d;
    logic [DATA_W-1:0] wdata_d;
    logic [DATA_W-1:0] ld_d;
    logic              past_ok;

    assign size_q = acc_size_e'(acc_size);

    lane_align_chk #(.DATA_W(DATA_W)) u_align (
        .size     (size_q),
        .off      (addr_lo),
        .misalign (mis_d)
    );

    lane_store_fmt #(.DATA_W(DATA_W)) u_store (
        .size     (size_q),
        .off      (addr_lo),
        .misalign (mis_d),
        .st_value (st_value),
        .be       (be_d),
        .wdata    (wdata_d)
    );

    lane_load_ext #(.DATA_W(DATA_W)) u_load (
        .size        (size_q),
        .is_unsigned (acc_unsigned),
        .off         (addr_lo),
        .misalign    (mis_d),
        .rdata       (mem_rdata),
        .result      (ld_d)
    );

    // Register every output; clear them all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_be    <= '0;
            mem_wdata <= '0;
            ld_result <= '0;
            misalign  <= 1'b0;
        end else begin
            mem_be    <= be_d;
            mem_wdata <= wdata_d;
            ld_result <= ld_d;
            misalign  <= mis_d;
        end
    end

    // Mark when the previous cycle's inputs were captured out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r10_no_be_when_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_be == '0 && ld_result == '0));

    a_r7_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(acc_size) == SZ_BYTE) |-> ($onehot(mem_be) && !misalign));

    a_r8_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(acc_size) == SZ_HALF && !misalign) |-> ($countones(mem_be) == 2));

    a_r4_unsigned_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(acc_size) == SZ_BYTE && $past(acc_unsigned))
            |-> (ld_result[DATA_W-1:8] == '0));

    a_r9_word_store_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(acc_size) == SZ_WORD && !misalign)
            |-> (mem_wdata == $past(st_value) && mem_be == '1));
endmodule

// File: tb/lane_lsu_tb.sv
`timescale 1ns/1ps
module lane_lsu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_size = '0;
    logic        acc_unsigned = 1'b0;
    logic [1:0]  addr_lo = '0;
    logic [31:0] st_value = '0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] ld_result;
    logic        misalign;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lane_lsu u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_size     (acc_size),
        .acc_unsigned (acc_unsigned),
        .addr_lo      (addr_lo),
        .st_value     (st_value),
        .mem_rdata    (mem_rdata),
        .mem_be       (mem_be),
        .mem_wdata    (mem_wdata),
        .ld_result    (ld_result),
        .misalign     (misalign)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_mis(input int sz, input int off);
        return (sz == 1 && (off % 2) == 1) || (sz >= 2 && off != 0);
    endfunction

    function automatic logic [31:0] exp_ld(input int sz, input bit uns, input int off,
                                           input logic [31:0] rd);
        logic [31:0] v;
        if (exp_mis(sz, off)) return 32'h0;
        if (sz == 0) begin
            v = (rd >> (8 * off)) & 32'hFF;
            if (!uns && v[7]) v = v | 32'hFFFF_FF00;
        end else if (sz == 1) begin
            v = (rd >> (16 * (off / 2))) & 32'hFFFF;
            if (!uns && v[15]) v = v | 32'hFFFF_0000;
        end else begin
            v = rd;
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_be(input int sz, input int off);
        if (exp_mis(sz, off)) return 32'h0;
        if (sz == 0) return 32'h1 << off;
        if (sz == 1) return 32'h3 << (2 * (off / 2));
        return 32'hF;
    endfunction

    function automatic logic [31:0] exp_wd(input int sz, input logic [31:0] sv);
        if (sz == 0) return (sv & 32'hFF) * 32'h0101_0101;
        if (sz == 1) return (sv & 32'hFFFF) * 32'h0001_0001;
        return sv;
    endfunction

    function automatic string ld_req(input int sz, input bit uns, input int off);
        if (exp_mis(sz, off)) return "R10";
        if (sz == 3) return "R11";
        if (sz == 0) return uns ? "R4" : "R3";
        if (sz == 1) return "R5";
        return "R6";
    endfunction

    function automatic string st_req(input int sz, input int off);
        if (exp_mis(sz, off)) return "R10";
        if (sz == 3) return "R11";
        if (sz == 0) return "R7";
        if (sz == 1) return "R8";
        return "R9";
    endfunction

    logic [31:0] rd_pat [6] = '{32'h80FF_7F01, 32'h7F80_01FE, 32'hC3A5_5A3C,
                                32'h0102_8384, 32'hFEDC_BA98, 32'h1357_9BDF};
    logic [31:0] sv_pat [6] = '{32'h1234_5678, 32'hA5C3_F00F, 32'h0000_80FF,
                                32'hFFFF_7F80, 32'h8001_0203, 32'h55AA_33CC};

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset clears every output even with busy inputs.
        @(negedge clk);
        acc_size = 2'b00; acc_unsigned = 1'b0; addr_lo = 2'd3;
        st_value = 32'hFFFF_FFFF; mem_rdata = 32'hFFFF_FFFF;
        @(posedge clk); @(negedge clk);
        check("R1", "be", {28'h0, mem_be}, 32'h0);
        check("R1", "wdata", mem_wdata, 32'h0);
        check("R1", "ld", ld_result, 32'h0);
        check("R1", "misalign", {31'h0, misalign}, 32'h0);
        rst_n = 1'b1;

        // Full sweep of size, sign mode, offset and data pattern.
        for (int p = 0; p < 6; p++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int u = 0; u < 2; u++) begin
                    for (int off = 0; off < 4; off++) begin
                        acc_size = 2'(sz); acc_unsigned = 1'(u); addr_lo = 2'(off);
                        st_value = sv_pat[p]; mem_rdata = rd_pat[p];
                        @(posedge clk); @(negedge clk);
                        check(ld_req(sz, 1'(u), off), "ld", ld_result,
                              exp_ld(sz, 1'(u), off, rd_pat[p]));
                        check(st_req(sz, off), "be", {28'h0, mem_be}, exp_be(sz, off));
                        check("R10", "misalign", {31'h0, misalign},
                              {31'h0, exp_mis(sz, off)});
                        if (!exp_mis(sz, off))
                            check(st_req(sz, off), "wdata", mem_wdata, exp_wd(sz, sv_pat[p]));
                    end
                end
            end
        end

        // R2: outputs hold between edges, then update one edge later.
        acc_size = 2'b10; acc_unsigned = 1'b0; addr_lo = 2'd0;
        st_value = 32'hDEAD_BEEF; mem_rdata = 32'h0BAD_F00D;
        @(posedge clk); @(negedge clk);
        st_value = 32'h1111_2222; mem_rdata = 32'h3333_4444;
        #1;
        check("R2", "wdata held", mem_wdata, 32'hDEAD_BEEF);
        check("R2", "ld held", ld_result, 32'h0BAD_F00D);
        @(posedge clk); @(negedge clk);
        check("R2", "wdata updated", mem_wdata, 32'h1111_2222);
        check("R2", "ld updated", ld_result, 32'h3333_4444);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule